// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write command into the stream of column addresses that the command's burst visits. A command gives a start column, a three-bit burst length code and an ordering bit. From the cycle after the command, the block presents one column address per clock. It marks the final beat of a finite burst, and it then falls idle. The address stays inside an aligned block whose size is the burst length. The low bits follow either a wrapping count (sequential ordering) or the start bits XORed with the beat number (interleaved ordering). The bits above the block stay fixed.

A full-page burst walks the whole column range, wrapping from the top column back to zero. It runs until a stop input or a new command ends it. A new command is taken on any cycle and replaces the burst in progress at once. An unsupported configuration raises an error flag and produces a single beat at the start column.

The control is a three-state machine:
- `ST_IDLE`: no beat is presented.
- `ST_FIN`: a burst of 1, 2, 4 or 8 beats is running.
- `ST_PAGE`: a full-page burst is running.

Its transitions are:
- launch: any state goes to `ST_FIN` or `ST_PAGE` when `start_i` is high.
- finish: `ST_FIN` goes to `ST_IDLE` after the last beat.
- halt: `ST_PAGE` goes to `ST_IDLE` when `stop_i` is high.
- hold: any other case keeps the current state.

Top module: `burst_col_gen`

## Requirements
- R1: The length code `len_code_i` selects 000 = 1 beat, 001 = 2 beats, 010 = 4 beats, 011 = 8 beats and 111 = full page.
- R2: A command sampled with `start_i` high at a clock edge shows its first beat in the cycle after that edge. In that cycle `col_vld_o` = 1 and `col_o` equals the start column.
- R3: With `itl_i` = 0 (sequential), beat k of a burst of N beats has low log2(N) bits equal to (start + k) mod N. Example: start 5, length 8 gives 5,6,7,0,1,2,3,4.
- R4: With `itl_i` = 1 (interleaved), beat k has low log2(N) bits equal to the start's low bits XOR k. Example: start 5, length 8 gives 5,4,7,6,1,0,3,2.
- R5: In bursts of 1, 2, 4 or 8 beats, every column bit above the lowest 0, 1, 2 or 3 bits keeps the start column's value for the whole burst.
- R6: `last_o` is high only on the final beat of a finite burst. In the next cycle `col_vld_o` is 0 unless a new command was sampled.
- R7: A command sampled during a running burst ends that burst. The next cycle shows the new command's first beat.
- R8: A full-page burst (code 111, `itl_i` = 0) steps the column by +1 every cycle. It wraps from the top column to 0 and never raises `last_o`.
- R9: When `stop_i` is sampled high during a full-page burst, the beat shown in that cycle is the last one and `col_vld_o` is 0 in the next cycle. `stop_i` has no effect on finite bursts.
- R10: Codes 100, 101 and 110, and code 111 with `itl_i` = 1, set `cfg_err_o` to 1 from the first beat. In each of these cases the burst is one beat at the start column, with `last_o` high. `cfg_err_o` holds until the next command.
- R11: While and after reset, with no command, `col_vld_o`, `last_o` and `cfg_err_o` are 0 and `col_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe; launches a new burst |
| start_col_i | input | COL_W | Start column of the command |
| len_code_i | input | 3 | Burst length code |
| itl_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Ends a full-page burst |
| col_o | output | COL_W | Column address of the current beat |
| col_vld_o | output | 1 | A beat is presented |
| last_o | output | 1 | Final beat of a finite burst |
| cfg_err_o | output | 1 | Last command had an unsupported configuration |

## Verification
The properties assume that `COL_W` is at least 4, so that the fixed upper field of an 8-beat burst is not empty. They also assume that inputs only change between clock edges. The bench keeps to the default column width of 9. It changes every input one time unit after a rising edge, so no input moves at a sampling edge.

The properties make no assumption about the codes that arrive. For this reason the stimulus also sends reserved codes and interleaved full-page requests on purpose. It also sends commands that overlap running bursts and stop pulses during finite bursts.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIN  = 2'd1,
        ST_PAGE = 2'd2
    } bcg_state_e;

    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } bcg_len_e;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode import burst_col_pkg::*; #(
    parameter int COL_W = 9
) (
    input  logic [2:0]       len_code,
    input  logic             itl,
    output logic [COL_W-1:0] mask,
    output logic             page,
    output logic             err
);
    localparam logic [COL_W-1:0] MASK_2 = COL_W'(1);
    localparam logic [COL_W-1:0] MASK_4 = COL_W'(3);
    localparam logic [COL_W-1:0] MASK_8 = COL_W'(7);

    always_comb begin
        mask = '0;
        page = 1'b0;
        err  = 1'b0;
        case (len_code)
            LEN_1: mask = '0;
            LEN_2: mask = MASK_2;
            LEN_4: mask = MASK_4;
            LEN_8: mask = MASK_8;
            LEN_PAGE: begin
                // full page is defined for sequential ordering only
                if (itl) begin
                    err = 1'b1;
                end else begin
                    mask = '1;
                    page = 1'b1;
                end
            end
            default: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             itl,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] seq_w;
    logic [COL_W-1:0] itl_w;
    logic [COL_W-1:0] low_w;

    assign seq_w = base + beat;
    assign itl_w = base ^ beat;
    assign low_w = itl ? itl_w : seq_w;

    // bits inside the aligned block move, bits above it stay at the start value
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign addr[i] = mask[i] ? low_w[i] : base[i];
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen import burst_col_pkg::*; #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             itl_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_vld_o,
    output logic             last_o,
    output logic             cfg_err_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, beat_q, mask_q;
    logic             itl_q, err_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page, dec_err;
    logic [COL_W-1:0] addr_w;
    logic             page_run;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code (len_code_i),
        .itl      (itl_i),
        .mask     (dec_mask),
        .page     (dec_page),
        .err      (dec_err)
    );

    bcg_addr_calc #(.COL_W(COL_W)) u_calc (
        .base (base_q),
        .beat (beat_q),
        .mask (mask_q),
        .itl  (itl_q),
        .addr (addr_w)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = dec_page ? ST_PAGE : ST_FIN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_FIN:  if (beat_q == mask_q) state_d = ST_IDLE;
                ST_PAGE: if (stop_i) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state and burst registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            itl_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                base_q <= start_col_i;
                beat_q <= '0;
                mask_q <= dec_mask;
                itl_q  <= itl_i;
                err_q  <= dec_err;
            end else if (state_q != ST_IDLE) begin
                beat_q <= beat_q + ONE;
            end
        end
    end

    assign page_run = (state_q == ST_PAGE);

    // outputs
    always_comb begin
        col_vld_o = (state_q != ST_IDLE);
        col_o     = col_vld_o ? addr_w : '0;
        last_o    = (state_q == ST_FIN) && (beat_q == mask_q);
        cfg_err_o = err_q;
    end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             col_vld_o,
    input logic             last_o,
    input logic             cfg_err_o,
    input logic             page_run
);
    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_vld_o && col_o == $past(start_col_i)));

    // R6
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !col_vld_o);

    // R6
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (col_vld_o && !page_run));

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld_o && !last_o && !start_i && !page_run) |=>
        (col_vld_o && col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

    // R8
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_run && !stop_i && !start_i) |=>
        (col_vld_o && col_o == $past(col_o) + COL_W'(1)));

    // R9
    page_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_run && stop_i && !start_i) |=> !col_vld_o);

    // R10
    err_no_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !page_run);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .col_vld_o   (col_vld_o),
    .last_o      (last_o),
    .cfg_err_o   (cfg_err_o),
    .page_run    (page_run)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             itl_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             col_vld_o, last_o, cfg_err_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .itl_i(itl_i), .stop_i(stop_i),
        .col_o(col_o), .col_vld_o(col_vld_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
    );

    // fields: code[84:82] type[81] start[80:72] beat0..beat7 (9 bits each, beat0 on top)
    localparam logic [84:0] VEC [0:7] = '{
        {3'b011, 1'b0, 9'd5,   9'd5,   9'd6,   9'd7,   9'd0,   9'd1,   9'd2,   9'd3,   9'd4},
        {3'b011, 1'b1, 9'd5,   9'd5,   9'd4,   9'd7,   9'd6,   9'd1,   9'd0,   9'd3,   9'd2},
        {3'b010, 1'b0, 9'd29,  9'd29,  9'd30,  9'd31,  9'd28,  9'd0,   9'd0,   9'd0,   9'd0},
        {3'b010, 1'b1, 9'd29,  9'd29,  9'd28,  9'd31,  9'd30,  9'd0,   9'd0,   9'd0,   9'd0},
        {3'b001, 1'b0, 9'd511, 9'd511, 9'd510, 9'd0,   9'd0,   9'd0,   9'd0,   9'd0,   9'd0},
        {3'b001, 1'b1, 9'd510, 9'd510, 9'd511, 9'd0,   9'd0,   9'd0,   9'd0,   9'd0,   9'd0},
        {3'b000, 1'b0, 9'd77,  9'd77,  9'd0,   9'd0,   9'd0,   9'd0,   9'd0,   9'd0,   9'd0},
        {3'b011, 1'b1, 9'd507, 9'd507, 9'd506, 9'd505, 9'd504, 9'd511, 9'd510, 9'd509, 9'd508}
    };

    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'b000:  return 1;
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    // reference from the ordering rules: beat k inside an aligned block of n
    function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] s,
                                                 input logic typ, input int n, input int k);
        int blk = s - (s % n);
        int off = s % n;
        int lo  = typ ? (off ^ k) : ((off + k) % n);
        return COL_W'(blk + lo);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive a command one unit after an edge; return once beat0 is visible
    task automatic fire(input logic [2:0] code, input logic typ, input logic [COL_W-1:0] s);
        start_i = 1'b1; len_code_i = code; itl_i = typ; start_col_i = s;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic next_beat();
        @(posedge clk); #1;
    endtask

    task automatic finite_burst(input logic [2:0] code, input logic typ,
                                input logic [COL_W-1:0] s, input string req);
        int n = beats_of(code);
        fire(code, typ, s);
        for (int k = 0; k < n; k++) begin
            if (k > 0) next_beat();
            chk({req, " col"}, col_o, ref_col(s, typ, n, k));
            chk("R6 last", last_o, (k == n - 1));
        end
        next_beat();
        chk("R6 idle after last", col_vld_o, 0);
    endtask

    task automatic main();
        // R11 reset state
        #3;
        chk("R11 vld in reset", col_vld_o, 0);
        chk("R11 err in reset", cfg_err_o, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        next_beat();
        chk("R11 vld after reset", col_vld_o, 0);
        chk("R11 col after reset", col_o, 0);
        chk("R11 last after reset", last_o, 0);

        // table walk: R3 R4 R1
        for (int v = 0; v < 8; v++) begin
            logic [2:0] code = VEC[v][84:82];
            logic typ = VEC[v][81];
            int n = beats_of(code);
            fire(code, typ, VEC[v][80:72]);
            chk("R2 first beat valid", col_vld_o, 1);
            for (int k = 0; k < n; k++) begin
                if (k > 0) next_beat();
                chk(typ ? "R4 table" : "R3 table", col_o, VEC[v][71-9*k -: 9]);
                chk("R1 length/last", last_o, (k == n - 1));
            end
            next_beat();
            chk("R6 idle", col_vld_o, 0);
        end

        // sweep every start for every finite length and both orderings: R3 R4 R5
        for (int c = 0; c < 4; c++) begin
            for (int t = 0; t < 2; t++) begin
                for (int s = 0; s < NCOL; s++) begin
                    finite_burst(3'(c), t[0], COL_W'(s), t ? "R4/R5 sweep" : "R3/R5 sweep");
                end
            end
        end

        // R8 full page from 500, through the wrap, then R9 stop
        fire(3'b111, 1'b0, COL_W'(500));
        for (int k = 0; k < 530; k++) begin
            if (k > 0) next_beat();
            chk("R8 page col", col_o, (500 + k) % NCOL);
            chk("R8 page no last", last_o, 0);
        end
        stop_i = 1'b1;
        next_beat();
        stop_i = 1'b0;
        chk("R9 stop ends page", col_vld_o, 0);
        chk("R10 page no err", cfg_err_o, 0);

        // R9 stop ignored for a finite burst
        fire(3'b011, 1'b0, COL_W'(2));
        for (int k = 0; k < 8; k++) begin
            if (k > 0) next_beat();
            stop_i = (k == 2);
            chk("R9 stop ignored col", col_o, ref_col(COL_W'(2), 1'b0, 8, k));
        end
        stop_i = 1'b0;
        next_beat();
        chk("R9 idle after 8", col_vld_o, 0);

        // R7 truncation of a finite burst by an interleaved 4-beat command
        fire(3'b011, 1'b0, COL_W'(8));
        next_beat(); next_beat();
        chk("R7 before cut", col_o, 10);
        fire(3'b010, 1'b1, COL_W'(33));
        for (int k = 0; k < 4; k++) begin
            if (k > 0) next_beat();
            chk("R7 new burst", col_o, ref_col(COL_W'(33), 1'b1, 4, k));
        end
        next_beat();
        chk("R7 idle", col_vld_o, 0);

        // R7 truncation of a full page burst
        fire(3'b111, 1'b0, COL_W'(100));
        next_beat(); next_beat();
        fire(3'b001, 1'b0, COL_W'(7));
        chk("R7 cut page beat0", col_o, 7);
        next_beat();
        chk("R7 cut page beat1", col_o, 6);
        chk("R7 cut page last", last_o, 1);

        // R10 reserved codes and interleaved full page
        for (int c = 4; c < 8; c++) begin
            fire(3'(c), (c == 7), COL_W'(300 + c));
            chk("R10 err", cfg_err_o, 1);
            chk("R10 col", col_o, 300 + c);
            chk("R10 single last", last_o, 1);
            next_beat();
            chk("R10 idle", col_vld_o, 0);
            chk("R10 err held", cfg_err_o, 1);
        end
        fire(3'b000, 1'b0, COL_W'(1));
        chk("R10 err cleared", cfg_err_o, 0);

        // R11 reset in the middle of a burst
        fire(3'b011, 1'b1, COL_W'(40));
        fire(3'b110, 1'b0, COL_W'(41));
        rst_n = 1'b0;
        #1;
        chk("R11 async vld", col_vld_o, 0);
        chk("R11 async err", cfg_err_o, 0);
        next_beat();
        rst_n = 1'b1;
        next_beat();
        chk("R11 stays idle", col_vld_o, 0);
    endtask

    initial begin
        fork
            main();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule